// File: doc/BRIEF.md
# Multi-slot micro-op decoupling queue

This block is a circular buffer placed between an instruction decoder and a dispatch stage, so that the two can run at different rates. Each instruction arrives with a tag and a micro-op count. It takes up as many consecutive slots as it has micro-ops. The tag and the count are kept only in the first of those slots. The decoder offers up to `WR_LANES` instructions per cycle on a valid/ready interface, and an accept limit can throttle how many of them are taken.

The dispatch side sees the oldest `RD_LANES` queued instructions at once, oldest on lane 0. In one cycle it takes any prefix of them by raising ready. Taking an instruction frees every slot it held.

A mode input picks when instructions become visible:
- **Normal mode:** draining happens at the start of the cycle. A newly written instruction can leave no earlier than the next cycle, and slots freed this cycle can already be refilled.
- **Zero-latency mode:** draining happens at the end of the cycle. Newly written instructions show up behind the stored ones and can leave in the same cycle, but freed slots only become writable in the next cycle.

Top module: `mq_decouple`

## Requirements
- R1: After reset the queue is empty: `free_slots` equals the slot count, `full` is 0 and every `out_valid` bit is 0.
- R2: A `DEPTH` of zero builds a queue of exactly one slot.
- R3: The count used for slot accounting, and shown on `out_uops`, is `in_uops` clamped to the range 1 to the slot count. A count of 0 is taken as 1, and a count above the slot count is taken as the slot count.
- R4: Write lane 0 is the oldest write lane. Lane i is ready only when three conditions hold: every lane below i is valid and taken; the slots still available cover the clamped count of lane i together with those of the lanes below it; and the accept limit is not yet reached.
- R5: `accept_limit` 0 allows any number of accepts per cycle. A nonzero value N allows at most N accepts per cycle.
- R6: `free_slots` falls by the clamped counts of the instructions accepted and rises by the counts of the instructions that leave. `full` is 1 exactly when `free_slots` is 0.
- R7: Read lane k shows the k-th oldest instruction. Instructions leave as the longest prefix of lanes with both valid and ready, so several can leave in one cycle.
- R8: With `zero_lat` at 0, an instruction accepted in a cycle is not shown until the next cycle. Slots freed in a cycle are available to the write side in that same cycle.
- R9: With `zero_lat` at 1, instructions accepted in a cycle are shown in the same cycle, behind all stored ones, and can leave at once. Slots freed in a cycle are not available to the write side until the next cycle.
- R10: The tag shown on a read lane is the tag given when that instruction was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| zero_lat | input | 1 | 1 = same-cycle pass-through mode, 0 = normal mode |
| accept_limit | input | LIM_W | Maximum accepts per cycle, 0 = unlimited |
| in_valid | input | WR_LANES | Write lane holds an instruction |
| in_tag | input | WR_LANES*TAG_W | Instruction tag per write lane |
| in_uops | input | WR_LANES*UOP_W | Micro-op count per write lane |
| in_ready | output | WR_LANES | Write lane would be accepted |
| out_valid | output | RD_LANES | Read lane holds an instruction |
| out_tag | output | RD_LANES*TAG_W | Tag per read lane |
| out_uops | output | RD_LANES*CNT_W | Clamped micro-op count per read lane |
| out_ready | input | RD_LANES | Downstream takes the read lane |
| free_slots | output | CNT_W | Number of free slots |
| full | output | 1 | No free slot left |

## Verification
The assertions expect all inputs to be driven to known levels whenever reset is released. They also expect the inputs to hold steady across each rising edge. They make no assumption about how write lanes are packed, because a lane above a gap is simply never ready. The stimulus changes inputs only at falling edges. It mixes zero micro-op counts and counts above the slot count with ordinary ones, so the clamp and the single-instruction-fills-everything case both occur. It also switches the mode and the accept limit between phases while entries are still queued, which exercises the stored/pass-through ordering the assertions rely on.

// File: rtl/mq_pkg.sv
package mq_pkg;

  // Advance a slot index by a step of at most one full lap.
  function automatic int mq_wrap(int idx, int step, int slots);
    int s;
    s = idx + step;
    return (s >= slots) ? s - slots : s;
  endfunction

  // Slot cost of an instruction: at least one slot, at most the whole queue.
  function automatic int mq_clamp(int raw, int slots);
    if (raw == 0) return 1;
    if (raw > slots) return slots;
    return raw;
  endfunction

endpackage

// File: rtl/mq_head_walk.sv
module mq_head_walk
  import mq_pkg::*;
#(
  parameter int RD_LANES = 2,
  parameter int SLOTS    = 8,
  parameter int TAG_W    = 8,
  parameter int CNT_W    = 4,
  parameter int IDX_W    = 3
) (
  input  logic [IDX_W-1:0]                head,
  input  logic [CNT_W-1:0]                n_insts,
  input  logic [SLOTS-1:0][TAG_W-1:0]     slot_tag,
  input  logic [SLOTS-1:0][CNT_W-1:0]     slot_cnt,
  input  logic [RD_LANES-1:0]             out_ready,
  output logic [RD_LANES-1:0]             st_vld,
  output logic [RD_LANES-1:0][TAG_W-1:0]  st_tag,
  output logic [RD_LANES-1:0][CNT_W-1:0]  st_cnt,
  output logic [RD_LANES-1:0][IDX_W-1:0]  st_idx,
  output logic [CNT_W-1:0]                freed_st
);

  // Follow the chain of first slots from the head; each hop skips the
  // slots that one instruction holds.
  always_comb begin
    int   idx;
    int   fr;
    logic go;
    idx = int'(head);
    fr  = 0;
    go  = 1'b1;
    for (int k = 0; k < RD_LANES; k++) begin
      st_idx[k] = IDX_W'(idx);
      st_vld[k] = (k < int'(n_insts));
      st_tag[k] = slot_tag[IDX_W'(idx)];
      st_cnt[k] = slot_cnt[IDX_W'(idx)];
      go = go & st_vld[k] & out_ready[k];
      if (go) fr = fr + int'(slot_cnt[IDX_W'(idx)]);
      idx = mq_wrap(idx, int'(slot_cnt[IDX_W'(idx)]), SLOTS);
    end
    freed_st = CNT_W'(fr);
  end

endmodule

// File: rtl/mq_wr_arb.sv
module mq_wr_arb
  import mq_pkg::*;
#(
  parameter int WR_LANES = 3,
  parameter int SLOTS    = 8,
  parameter int UOP_W    = 4,
  parameter int CNT_W    = 4,
  parameter int IDX_W    = 3,
  parameter int LIM_W    = 2,
  parameter int WN_W     = 2
) (
  input  logic [WR_LANES-1:0]             in_valid,
  input  logic [WR_LANES-1:0][UOP_W-1:0]  in_uops,
  input  logic [CNT_W-1:0]                avail,
  input  logic [IDX_W-1:0]                tail,
  input  logic [LIM_W-1:0]                accept_limit,
  output logic [WR_LANES-1:0]             in_ready,
  output logic [WR_LANES-1:0]             acc,
  output logic [WR_LANES-1:0][CNT_W-1:0]  lane_cnt,
  output logic [WR_LANES-1:0][IDX_W-1:0]  lane_pos,
  output logic [CNT_W-1:0]                sum_in,
  output logic [WN_W-1:0]                 n_acc
);

  for (genvar g = 0; g < WR_LANES; g++) begin : g_clamp
    assign lane_cnt[g] = CNT_W'(mq_clamp(int'(in_uops[g]), SLOTS));
  end

  always_comb begin
    int   used;
    int   pos;
    int   nacc;
    logic go;
    used = 0;
    pos  = int'(tail);
    nacc = 0;
    go   = 1'b1;
    for (int i = 0; i < WR_LANES; i++) begin
      lane_pos[i] = IDX_W'(pos);
      in_ready[i] = go && (used + int'(lane_cnt[i]) <= int'(avail)) &&
                    ((accept_limit == '0) || (nacc < int'(accept_limit)));
      acc[i] = in_valid[i] & in_ready[i];
      if (acc[i]) begin
        used = used + int'(lane_cnt[i]);
        nacc = nacc + 1;
        pos  = mq_wrap(pos, int'(lane_cnt[i]), SLOTS);
      end
      go = go & acc[i];
    end
    sum_in = CNT_W'(used);
    n_acc  = WN_W'(nacc);
  end

endmodule

// File: rtl/mq_out_mux.sv
module mq_out_mux #(
  parameter int WR_LANES = 3,
  parameter int RD_LANES = 2,
  parameter int TAG_W    = 8,
  parameter int CNT_W    = 4,
  parameter int WN_W     = 2,
  parameter int RN_W     = 2
) (
  input  logic                            zero_lat,
  input  logic [CNT_W-1:0]                n_insts,
  input  logic [RD_LANES-1:0]             st_vld,
  input  logic [RD_LANES-1:0][TAG_W-1:0]  st_tag,
  input  logic [RD_LANES-1:0][CNT_W-1:0]  st_cnt,
  input  logic [WR_LANES-1:0][TAG_W-1:0]  in_tag,
  input  logic [WR_LANES-1:0][CNT_W-1:0]  lane_cnt,
  input  logic [WN_W-1:0]                 n_acc,
  input  logic [RD_LANES-1:0]             out_ready,
  output logic [RD_LANES-1:0]             out_valid,
  output logic [RD_LANES-1:0][TAG_W-1:0]  out_tag,
  output logic [RD_LANES-1:0][CNT_W-1:0]  out_uops,
  output logic [RD_LANES-1:0]             st_dep,
  output logic [WR_LANES-1:0]             byp_dep,
  output logic [CNT_W-1:0]                sum_out,
  output logic [RN_W-1:0]                 n_dq
);

  // Stored instructions first; in pass-through mode the accepted write
  // lanes queue up behind them.
  always_comb begin
    int   so;
    int   nd;
    int   src;
    logic go;
    so = 0;
    nd = 0;
    go = 1'b1;
    out_valid = '0;
    out_tag   = '0;
    out_uops  = '0;
    st_dep    = '0;
    byp_dep   = '0;
    for (int k = 0; k < RD_LANES; k++) begin
      src = -1;
      if (st_vld[k]) begin
        out_valid[k] = 1'b1;
        out_tag[k]   = st_tag[k];
        out_uops[k]  = st_cnt[k];
      end else if (zero_lat) begin
        for (int j = 0; j < WR_LANES; j++) begin
          if ((j + int'(n_insts) == k) && (j < int'(n_acc))) begin
            src          = j;
            out_valid[k] = 1'b1;
            out_tag[k]   = in_tag[j];
            out_uops[k]  = lane_cnt[j];
          end
        end
      end
      go = go & out_valid[k] & out_ready[k];
      if (go) begin
        so = so + int'(out_uops[k]);
        nd = nd + 1;
        st_dep[k] = st_vld[k];
        for (int j = 0; j < WR_LANES; j++) begin
          if (j == src) byp_dep[j] = 1'b1;
        end
      end
    end
    sum_out = CNT_W'(so);
    n_dq    = RN_W'(nd);
  end

endmodule

// File: rtl/mq_decouple.sv
module mq_decouple
  import mq_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int WR_LANES = 3,
  parameter int RD_LANES = 2,
  parameter int TAG_W    = 8,
  parameter int UOP_W    = 4,
  parameter int LIM_W    = 2,
  localparam int SLOTS   = (DEPTH == 0) ? 1 : DEPTH,
  localparam int CNT_W   = $clog2(SLOTS + 1),
  localparam int IDX_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int WN_W    = $clog2(WR_LANES + 1),
  localparam int RN_W    = $clog2(RD_LANES + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            zero_lat,
  input  logic [LIM_W-1:0]                accept_limit,
  input  logic [WR_LANES-1:0]             in_valid,
  input  logic [WR_LANES-1:0][TAG_W-1:0]  in_tag,
  input  logic [WR_LANES-1:0][UOP_W-1:0]  in_uops,
  output logic [WR_LANES-1:0]             in_ready,
  output logic [RD_LANES-1:0]             out_valid,
  output logic [RD_LANES-1:0][TAG_W-1:0]  out_tag,
  output logic [RD_LANES-1:0][CNT_W-1:0]  out_uops,
  input  logic [RD_LANES-1:0]             out_ready,
  output logic [CNT_W-1:0]                free_slots,
  output logic                            full
);

  logic [IDX_W-1:0]               head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0]               free_q, free_d, ninst_q, ninst_d;
  logic [SLOTS-1:0]               vld_q, vld_d;
  logic [SLOTS-1:0][TAG_W-1:0]    tag_q, tag_d;
  logic [SLOTS-1:0][CNT_W-1:0]    cnt_q, cnt_d;

  logic [RD_LANES-1:0]            st_vld, st_dep;
  logic [RD_LANES-1:0][TAG_W-1:0] st_tag;
  logic [RD_LANES-1:0][CNT_W-1:0] st_cnt;
  logic [RD_LANES-1:0][IDX_W-1:0] st_idx;
  logic [CNT_W-1:0]               freed_st, avail, sum_in, sum_out;
  logic [WR_LANES-1:0]            acc, byp_dep;
  logic [WR_LANES-1:0][CNT_W-1:0] lane_cnt;
  logic [WR_LANES-1:0][IDX_W-1:0] lane_pos;
  logic [WN_W-1:0]                n_acc;
  logic [RN_W-1:0]                n_dq;
  logic                           upd;

  mq_head_walk #(
    .RD_LANES(RD_LANES), .SLOTS(SLOTS), .TAG_W(TAG_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_walk (
    .head(head_q), .n_insts(ninst_q), .slot_tag(tag_q), .slot_cnt(cnt_q),
    .out_ready(out_ready), .st_vld(st_vld), .st_tag(st_tag), .st_cnt(st_cnt),
    .st_idx(st_idx), .freed_st(freed_st)
  );

  // Normal mode drains before writing, so freed slots count as available.
  assign avail = zero_lat ? free_q : CNT_W'(int'(free_q) + int'(freed_st));

  mq_wr_arb #(
    .WR_LANES(WR_LANES), .SLOTS(SLOTS), .UOP_W(UOP_W), .CNT_W(CNT_W),
    .IDX_W(IDX_W), .LIM_W(LIM_W), .WN_W(WN_W)
  ) u_arb (
    .in_valid(in_valid), .in_uops(in_uops), .avail(avail), .tail(tail_q),
    .accept_limit(accept_limit), .in_ready(in_ready), .acc(acc),
    .lane_cnt(lane_cnt), .lane_pos(lane_pos), .sum_in(sum_in), .n_acc(n_acc)
  );

  mq_out_mux #(
    .WR_LANES(WR_LANES), .RD_LANES(RD_LANES), .TAG_W(TAG_W), .CNT_W(CNT_W),
    .WN_W(WN_W), .RN_W(RN_W)
  ) u_mux (
    .zero_lat(zero_lat), .n_insts(ninst_q), .st_vld(st_vld), .st_tag(st_tag),
    .st_cnt(st_cnt), .in_tag(in_tag), .lane_cnt(lane_cnt), .n_acc(n_acc),
    .out_ready(out_ready), .out_valid(out_valid), .out_tag(out_tag),
    .out_uops(out_uops), .st_dep(st_dep), .byp_dep(byp_dep),
    .sum_out(sum_out), .n_dq(n_dq)
  );

  // Next state: clear departing stored heads, write accepted lanes, then
  // clear lanes that passed straight through.
  always_comb begin
    vld_d = vld_q;
    tag_d = tag_q;
    cnt_d = cnt_q;
    for (int k = 0; k < RD_LANES; k++) begin
      if (st_dep[k]) vld_d[st_idx[k]] = 1'b0;
    end
    for (int i = 0; i < WR_LANES; i++) begin
      if (acc[i]) begin
        vld_d[lane_pos[i]] = 1'b1;
        tag_d[lane_pos[i]] = in_tag[i];
        cnt_d[lane_pos[i]] = lane_cnt[i];
      end
    end
    for (int i = 0; i < WR_LANES; i++) begin
      if (byp_dep[i]) vld_d[lane_pos[i]] = 1'b0;
    end
    head_d  = IDX_W'(mq_wrap(int'(head_q), int'(sum_out), SLOTS));
    tail_d  = IDX_W'(mq_wrap(int'(tail_q), int'(sum_in), SLOTS));
    free_d  = CNT_W'(int'(free_q) + int'(sum_out) - int'(sum_in));
    ninst_d = CNT_W'(int'(ninst_q) + int'(n_acc) - int'(n_dq));
    upd     = (|acc) | (|st_dep) | (|byp_dep);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      free_q  <= CNT_W'(SLOTS);
      ninst_q <= '0;
      vld_q   <= '0;
    end else if (upd) begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      free_q  <= free_d;
      ninst_q <= ninst_d;
      vld_q   <= vld_d;
    end
  end

  // Payload storage needs no reset: it is read only behind a valid head.
  always_ff @(posedge clk) begin
    if (upd) begin
      tag_q <= tag_d;
      cnt_q <= cnt_d;
    end
  end

  assign free_slots = free_q;
  assign full       = (free_q == '0);

  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_q) <= SLOTS);                                             // R6
  AST_EMPTY_ALL_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (ninst_q == '0) |-> (int'(free_q) == SLOTS));                       // R6
  AST_HEAD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (ninst_q != '0) |-> vld_q[head_q]);                                 // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sum_in) <= int'(avail));                                       // R4
  AST_ACCEPT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_limit != '0) |-> (int'(n_acc) <= int'(accept_limit)));      // R5
  AST_NORMAL_STORED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_lat |-> (int'(n_dq) <= int'(ninst_q)));                       // R8
  AST_ZL_NO_REUSE: assert property (@(posedge clk) disable iff (!rst_n)
    zero_lat |-> (int'(sum_in) <= int'(free_q)));                       // R9
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (full && zero_lat) |-> !in_ready[0]);                               // R6
  AST_CLAMPED_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[0] |-> (out_uops[0] != '0 && int'(out_uops[0]) <= SLOTS)); // R3

endmodule

// File: tb/mq_decouple_tb.sv
`timescale 1ns/1ps
module mq_decouple_tb;

  localparam int DEPTH = 8;
  localparam int WR    = 3;
  localparam int RD    = 2;
  localparam int TW    = 8;
  localparam int UW    = 4;
  localparam int LW    = 2;
  localparam int CW    = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic zero_lat;
  logic [LW-1:0]         accept_limit;
  logic [WR-1:0]         in_valid;
  logic [WR-1:0][TW-1:0] in_tag;
  logic [WR-1:0][UW-1:0] in_uops;
  logic [WR-1:0]         in_ready;
  logic [RD-1:0]         out_valid;
  logic [RD-1:0][TW-1:0] out_tag;
  logic [RD-1:0][CW-1:0] out_uops;
  logic [RD-1:0]         out_ready;
  logic [CW-1:0]         free_slots;
  logic                  full;

  logic            s_zl, s_valid, s_ready, s_ovalid, s_oready, s_full;
  logic [LW-1:0]   s_lim;
  logic [TW-1:0]   s_tag, s_otag;
  logic [UW-1:0]   s_uops;
  logic [0:0]      s_ouops, s_free;

  int n_chk  = 0;
  int n_fail = 0;
  int mq_tag[$];
  int mq_cnt[$];
  int m_free;

  always #2.5 clk = ~clk;

  mq_decouple #(.DEPTH(DEPTH), .WR_LANES(WR), .RD_LANES(RD), .TAG_W(TW),
                .UOP_W(UW), .LIM_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .zero_lat(zero_lat), .accept_limit(accept_limit),
    .in_valid(in_valid), .in_tag(in_tag), .in_uops(in_uops), .in_ready(in_ready),
    .out_valid(out_valid), .out_tag(out_tag), .out_uops(out_uops),
    .out_ready(out_ready), .free_slots(free_slots), .full(full)
  );

  mq_decouple #(.DEPTH(0), .WR_LANES(1), .RD_LANES(1), .TAG_W(TW),
                .UOP_W(UW), .LIM_W(LW)) u_dut_one (
    .clk(clk), .rst_n(rst_n), .zero_lat(s_zl), .accept_limit(s_lim),
    .in_valid(s_valid), .in_tag(s_tag), .in_uops(s_uops), .in_ready(s_ready),
    .out_valid(s_ovalid), .out_tag(s_otag), .out_uops(s_ouops),
    .out_ready(s_oready), .free_slots(s_free), .full(s_full)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int bclamp(int raw);
    if (raw == 0) return 1;
    if (raw > DEPTH) return DEPTH;
    return raw;
  endfunction

  // One cycle: settle, predict from the reference queue, compare, clock.
  task automatic step(string req);
    int st_n, fr, avail, used, nacc, vis, nd, so, c;
    bit go;
    logic [WR-1:0] er;
    int lt[$];
    int lc[$];
    #1;
    st_n = mq_tag.size();
    fr = 0;
    go = 1'b1;
    for (int k = 0; k < RD; k++) begin
      if (go && k < st_n && out_ready[k]) fr += mq_cnt[k];
      else go = 1'b0;
    end
    avail = zero_lat ? m_free : m_free + fr;
    used = 0;
    nacc = 0;
    go = 1'b1;
    er = '0;
    lt = mq_tag;
    lc = mq_cnt;
    for (int i = 0; i < WR; i++) begin
      c = bclamp(int'(in_uops[i]));
      er[i] = go && (used + c <= avail) &&
              (accept_limit == 0 || nacc < int'(accept_limit));
      if (in_valid[i] && er[i]) begin
        used += c;
        nacc++;
        lt.push_back(int'(in_tag[i]));
        lc.push_back(c);
      end else begin
        go = 1'b0;
      end
    end
    vis = zero_lat ? st_n + nacc : st_n;
    chk(req, "R4 in_ready", int'(in_ready), int'(er));
    for (int k = 0; k < RD; k++) begin
      chk(req, "R7 out_valid", int'(out_valid[k]), int'(k < vis));
      if (k < vis) begin
        chk(req, "R10 out_tag", int'(out_tag[k]), lt[k]);
        chk(req, "R3 out_uops", int'(out_uops[k]), lc[k]);
      end
    end
    chk(req, "R6 free_slots", int'(free_slots), m_free);
    chk(req, "R6 full", int'(full), int'(m_free == 0));
    nd = 0;
    so = 0;
    go = 1'b1;
    for (int k = 0; k < RD; k++) begin
      if (go && k < vis && out_ready[k]) begin
        so += lc[k];
        nd++;
      end else begin
        go = 1'b0;
      end
    end
    @(posedge clk);
    for (int n = 0; n < nd; n++) begin
      void'(lt.pop_front());
      void'(lc.pop_front());
    end
    mq_tag = lt;
    mq_cnt = lc;
    m_free = m_free - used + so;
    @(negedge clk);
  endtask

  task automatic rand_in(int vpct, int rpct, int maxu);
    for (int i = 0; i < WR; i++) begin
      in_valid[i] = ($urandom_range(0, 99) < vpct);
      in_tag[i]   = TW'($urandom);
      in_uops[i]  = UW'($urandom_range(0, maxu));
    end
    for (int k = 0; k < RD; k++) out_ready[k] = ($urandom_range(0, 99) < rpct);
  endtask

  task automatic run(string req, int n, int vpct, int rpct, int maxu);
    for (int t = 0; t < n; t++) begin
      rand_in(vpct, rpct, maxu);
      step(req);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    zero_lat = 1'b0;
    accept_limit = '0;
    in_valid = '0;
    in_tag = '0;
    in_uops = '0;
    out_ready = '0;
    s_zl = 1'b0;
    s_lim = '0;
    s_valid = 1'b0;
    s_tag = '0;
    s_uops = '0;
    s_oready = 1'b0;
    m_free = DEPTH;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: empty after reset
    chk("R1", "free_slots", int'(free_slots), DEPTH);
    chk("R1", "full", int'(full), 0);
    chk("R1", "out_valid", int'(out_valid), 0);
    step("R1");

    // R8: normal mode hides a fresh write until the next cycle
    in_valid = 3'b001; in_tag[0] = 8'hA5; in_uops[0] = 4'd2; out_ready = 2'b11;
    step("R8");
    in_valid = '0;
    step("R8");

    // R9: zero-latency mode passes a fresh write through at once
    zero_lat = 1'b1;
    in_valid = 3'b001; in_tag[0] = 8'h5A; in_uops[0] = 4'd3;
    #1;
    chk("R9", "same-cycle out_valid", int'(out_valid[0]), 1);
    step("R9");
    in_valid = '0;
    step("R9");

    // R3: oversized count fills the empty queue alone
    zero_lat = 1'b0;
    out_ready = '0;
    in_valid = 3'b001; in_tag[0] = 8'h77; in_uops[0] = 4'd15;
    step("R3");
    in_valid = 3'b001; in_uops[0] = 4'd0;
    step("R3");
    out_ready = 2'b01; in_valid = '0;
    step("R3");

    run("R7", 400, 70, 60, 4);
    run("R6", 60, 90, 10, 3);
    accept_limit = 2'd1;
    run("R5", 300, 80, 60, 3);
    accept_limit = 2'd2;
    run("R5", 300, 80, 60, 3);
    accept_limit = '0;
    zero_lat = 1'b1;
    run("R9", 400, 70, 60, 4);
    run("R3", 300, 70, 60, 15);
    zero_lat = 1'b0;
    run("R8", 300, 70, 50, 15);
    out_ready = '0;
    in_valid = '0;
    repeat (3) step("R6");
    out_ready = '1;
    repeat (8) step("R7");

    // R2: zero depth behaves as one slot
    #1;
    chk("R2", "free_slots", int'(s_free), 1);
    s_valid = 1'b1; s_tag = 8'h3C; s_uops = 4'd3;
    #1;
    chk("R2", "in_ready", int'(s_ready), 1);
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    #1;
    chk("R2", "free_slots after write", int'(s_free), 0);
    chk("R2", "full", int'(s_full), 1);
    chk("R2", "out_valid", int'(s_ovalid), 1);
    chk("R2", "out_uops", int'(s_ouops), 1);
    chk("R2", "out_tag", int'(s_otag), 8'h3C);
    s_oready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #1;
    chk("R2", "out_valid after drain", int'(s_ovalid), 0);
    chk("R2", "free_slots after drain", int'(s_free), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule